// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

This block monitors eight bidirectional port pins, organised as two 4-bit ports, and produces one shared interrupt request when any pin that is currently an input makes the selected transition. A single polarity bit picks falling or rising detection. Detection works on the group as a whole rather than per pin. The first qualifying edge fires the request and disarms the detector. It rearms only after every participating pin has gone back to its idle level: high in falling mode, low in rising mode.

The pins pass through a synchroniser. Each edge is found by comparing the synchronised level with the level one cycle earlier. Configuration comes through a small write port. Two addresses hold the direction nibbles, one holds the control bits, and one clears the request. The request flag is sticky and sets whether or not the enable is on. The enable only gates the interrupt line sent to the processor. A separate wake line follows the raw flag, so a halted processor can resume even when the interrupt is masked. All pins are plain level signals with no valid/ready handshake. Each write takes effect in the cycle it is presented, and the port never stalls.

Top module: `pin_group_irq`

## Requirements
- R1: A qualifying transition on any participating pin sets the shared request flag. Bits 3:0 of `pins_i` form the first port and bits 7:4 the second. `req_o` reads 1 after the third rising clock edge following the pin change, and still reads 0 after the second.
- R2: A pin takes part only while its direction bit is 0 (input). Write address 0 loads the first port's direction nibble into `dir_o[3:0]`, and address 1 loads the second port's into `dir_o[7:4]`. Edges on pins whose direction bit is 1 never set the request.
- R3: Write address 2 loads the control bits: bit 0 is the interrupt enable and bit 1 is the polarity. With polarity 0, a high-to-low transition qualifies. With polarity 1, a low-to-high transition qualifies.
- R4: Once the request has fired, the detector ignores further qualifying transitions until every participating pin is back at the idle level (high for polarity 0, low for polarity 1). The next qualifying transition after that fires again.
- R5: After reset, the polarity is 0, all direction bits are 0, and the enable, request, interrupt and wake outputs are all 0.
- R6: The request flag stays set until a write to address 3 with data bit 0 at 1. It sets whether or not the enable is on. A write to address 3 with bit 0 at 0 leaves it unchanged.
- R7: `irq_o` is high exactly when both the request flag and the enable are high. `wake_o` follows the request flag regardless of the enable.
- R8: A write to addresses 0 to 2 never sets the request by itself. It re-evaluates the armed state from the pin levels present at that moment: the detector is armed only if all participating pins are idle.
- R9: A pin already at the active level when reset is released does not raise a request. The detector arms only once all participating pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Pin levels, two 4-bit ports |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | 0/1 direction nibbles, 2 control, 3 request clear |
| wr_data | input | 4 | Write data |
| dir_o | output | 8 | Current direction bits (1 = output, excluded) |
| rise_o | output | 1 | Current polarity (1 = rising) |
| en_o | output | 1 | Current interrupt enable |
| req_o | output | 1 | Sticky request flag |
| irq_o | output | 1 | Request gated by enable |
| wake_o | output | 1 | Wake-from-halt indication |

## Verification
A pin change becomes visible on the request three rising edges after it is driven: two synchroniser stages, then the flag register. A configuration write or clear takes effect on the edge that captures it, and the rearm evaluation follows one edge later. The bench drives every stimulus on a falling edge. It then lets four rising edges pass and samples on the following falling edge, so each result has settled before it is compared. One directed case samples at both the second and the third edge to pin down the exact latency.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RISE_BIT = 1;
  localparam int CLR_BIT       = 0;

  typedef struct packed {
    logic rise;
    logic en;
  } pcd_ctrl_t;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W       = 8,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= {W{RST_V}};
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= {W{RST_V}};
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
  import pcd_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int PORT_W  = 4,
  parameter int ADDR_W  = 2,
  localparam int PINS   = N_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              trig_i,
  output logic [PINS-1:0]   dir_o,
  output pcd_ctrl_t         ctrl_o,
  output logic              req_o,
  output logic              cfg_upd_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(N_PORTS);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(N_PORTS + 1);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dir_o[p*PORT_W +: PORT_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(p))
        dir_o[p*PORT_W +: PORT_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      ctrl_o.en   <= wr_data[CTRL_EN_BIT];
      ctrl_o.rise <= wr_data[CTRL_RISE_BIT];
    end
  end

  logic clr_hit;
  assign clr_hit = wr_en && (wr_addr == A_CLR) && wr_data[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_o <= 1'b0;
    else if (trig_i)  req_o <= 1'b1;
    else if (clr_hit) req_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_upd_o <= 1'b0;
    else        cfg_upd_o <= wr_en && (wr_addr <= A_CTRL);
  end
endmodule

// File: rtl/pcd_arm.sv
module pcd_arm #(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PRIME      = SYNC_STAGES + 1,
  localparam int CNT_W      = $clog2(PRIME + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] lvl_i,
  input  logic [PINS-1:0] dir_i,
  input  logic            rise_i,
  input  logic            cfg_upd_i,
  output logic            trig_o,
  output logic            armed_o
);
  logic [PINS-1:0] prev;
  logic [PINS-1:0] act_now, act_old, part;
  logic            any_edge, all_idle, primed;
  logic [CNT_W-1:0] cnt;

  assign part     = ~dir_i;
  assign act_now  = rise_i ? lvl_i : ~lvl_i;
  assign act_old  = rise_i ? prev  : ~prev;
  assign any_edge = |(act_now & ~act_old & part);
  assign all_idle = ~|(act_now & part);
  assign primed   = (cnt == CNT_W'(PRIME));
  assign trig_o   = primed && !cfg_upd_i && armed_o && any_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '1;
      cnt     <= '0;
      armed_o <= 1'b0;
    end else begin
      prev <= lvl_i;
      if (!primed) begin
        cnt     <= cnt + 1'b1;
        armed_o <= 1'b0;
      end else if (cfg_upd_i) begin
        armed_o <= all_idle;
      end else if (trig_o) begin
        armed_o <= 1'b0;
      end else if (!armed_o && all_idle) begin
        armed_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_group_irq.sv
module pin_group_irq
  import pcd_pkg::*;
#(
  parameter int N_PORTS     = 2,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = N_PORTS * PORT_W,
  localparam int ADDR_W     = $clog2(N_PORTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pins_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PINS-1:0]   dir_o,
  output logic              rise_o,
  output logic              en_o,
  output logic              req_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [PINS-1:0] lvl_w;
  logic            trig_w, armed_w, cfg_upd_w;
  pcd_ctrl_t       ctrl_w;

  pcd_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(lvl_w)
  );

  pcd_regs #(.N_PORTS(N_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_i(trig_w), .dir_o(dir_o), .ctrl_o(ctrl_w),
    .req_o(req_o), .cfg_upd_o(cfg_upd_w)
  );

  pcd_arm #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_arm (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .dir_i(dir_o),
    .rise_i(ctrl_w.rise), .cfg_upd_i(cfg_upd_w), .trig_o(trig_w),
    .armed_o(armed_w)
  );

  assign rise_o = ctrl_w.rise;
  assign en_o   = ctrl_w.en;
  assign irq_o  = req_o & ctrl_w.en;
  assign wake_o = req_o;
endmodule

// File: rtl/pin_group_irq_chk.sv
module pin_group_irq_chk #(
  parameter int ADDR_W = 2,
  parameter int PORT_W = 4,
  parameter int N_PORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PORT_W-1:0] wr_data,
  input logic              req_o,
  input logic              irq_o,
  input logic              en_o,
  input logic              trig,
  input logic              armed,
  input logic              cfg_upd
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(N_PORTS + 1);
  logic clr_w;
  assign clr_w = wr_en && wr_addr == A_CLR && wr_data[0];

  a_r6_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !clr_w) |=> req_o);
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !trig) |=> !req_o);
  a_r1_trig_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> req_o);
  a_r4_disarm_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !armed);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> !trig);
  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_o);
endmodule

bind pin_group_irq pin_group_irq_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .N_PORTS(N_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .req_o(req_o), .irq_o(irq_o), .en_o(en_o),
  .trig(trig_w), .armed(armed_w), .cfg_upd(cfg_upd_w)
);

// File: tb/tb_pin_group_irq.sv
`timescale 1ns/1ps
module tb_pin_group_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFE;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [7:0] dir_o;
  logic       rise_o, en_o, req_o, irq_o, wake_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] dir_m = '0;
  logic rise_m = 0, en_m = 0, req_m = 0, armed_m = 0;

  always #2.5 clk = ~clk;

  pin_group_irq dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dir_o(dir_o), .rise_o(rise_o),
    .en_o(en_o), .req_o(req_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic [7:0] act_of(logic [7:0] p, logic r);
    return r ? p : ~p;
  endfunction

  function automatic logic idle_all(logic [7:0] p, logic [7:0] d, logic r);
    return (act_of(p, r) & ~d) == 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " req"}, {7'b0, req_o}, {7'b0, req_m});
    chk({tag, " irq R7"}, {7'b0, irq_o}, {7'b0, req_m & en_m});
    chk({tag, " wake R7"}, {7'b0, wake_o}, {7'b0, req_m});
    chk({tag, " dir R2"}, dir_o, dir_m);
    chk({tag, " ctrl R3"}, {6'b0, rise_o, en_o}, {6'b0, rise_m, en_m});
  endtask

  task automatic set_pins(logic [7:0] nv);
    logic [7:0] old = pins;
    pins = nv;
    tick(4);
    if (armed_m && ((act_of(nv, rise_m) & ~act_of(old, rise_m) & ~dir_m) != 0)) begin
      req_m = 1'b1;
      armed_m = 1'b0;
    end
    if (!armed_m && idle_all(nv, dir_m, rise_m)) armed_m = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    tick(3);
    case (a)
      2'd0: dir_m[3:0] = d;
      2'd1: dir_m[7:4] = d;
      2'd2: begin en_m = d[0]; rise_m = d[1]; end
      default: if (d[0]) req_m = 1'b0;
    endcase
    if (a != 2'd3) armed_m = idle_all(pins, dir_m, rise_m);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    // R5: reset values while reset is held
    check_all("R5 reset");
    rst_n = 1'b1;
    tick(8);
    // R9: pin 0 already low at release, no request
    armed_m = idle_all(pins, dir_m, rise_m);
    check_all("R9 held-active");
    set_pins(8'hFF);
    check_all("R9 rearm");
    // R1: exact latency on a second-port pin
    pins = 8'hDF;
    tick(2);
    chk("R1 not yet at 2", {7'b0, req_o}, 8'h00);
    tick(1);
    chk("R1 set at 3", {7'b0, req_o}, 8'h01);
    req_m = 1'b1; armed_m = 1'b0;
    // R6: clear with bit0=0 is ignored, bit0=1 clears
    wr(2'd3, 4'b1110);
    check_all("R6 clear ignored");
    wr(2'd3, 4'b0001);
    check_all("R6 cleared");
    // R4: further falls while pin 5 still low are ignored
    set_pins(8'hDE);
    check_all("R4 ignored");
    set_pins(8'hFF);
    set_pins(8'hFB);
    check_all("R4 refire");
    wr(2'd3, 4'b0001);
    set_pins(8'hFF);
    // R2: first port as outputs does not fire
    wr(2'd0, 4'hF);
    set_pins(8'hF0);
    check_all("R2 masked");
    set_pins(8'h70);
    check_all("R2 second port fires");
    wr(2'd3, 4'b0001);
    wr(2'd0, 4'h0);
    // R8: re-enabling inputs with pins low sets no request
    check_all("R8 dir change");
    set_pins(8'hFF);
    // R3: rising mode, enable on
    wr(2'd2, 4'b0011);
    check_all("R8 polarity change");
    set_pins(8'h00);
    set_pins(8'h08);
    check_all("R3 rising fire R7");
    wr(2'd3, 4'b0001);
    wr(2'd2, 4'b0000);
    set_pins(8'hFF);
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) set_pins(pins ^ 8'($urandom_range(0, 255) & $urandom_range(0, 255)));
      else if (op == 6) wr(2'($urandom_range(0, 1)), 4'($urandom_range(0, 15) & $urandom_range(0, 15)));
      else if (op == 7) wr(2'd2, 4'($urandom_range(0, 3)));
      else wr(2'd3, 4'($urandom_range(0, 15)));
      check_all("R4 R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule